// File: doc/BRIEF.md
# Interrupt Output Hold Arbiter

This block sits beside a microcontroller core that can give its external bus to another master. It runs the bus hold handshake: it takes the active-low hold request from the external master and returns an active-low hold acknowledge. It also drives two more active-low outputs. The first is an interrupt output, which tells the external master that an interrupt is pending and needs the external bus. The second is a bus request, which asks for the bus back.

When the interrupt output is raised depends on the phase of the handshake and on where code is being fetched from. If code runs from internal memory, an interrupt during hold is signalled at once, because the core can keep working without the bus. If code runs from external memory, the block first asks for the bus back and signals the interrupt only once the master lets go. If the interrupt arrives while hold is being granted, the acknowledge and the interrupt output are raised together and held until the master releases the bus.

Top module: `hold_irq_arbiter`

## Requirements
- R1: While reset is low, and on the first cycle after it, `hlda_n`, `breq_n` and `intout_n` are all 1, and the block is not in hold.
- R2: With no interrupt pending, `hlda_n` goes to 0 after the second consecutive rising edge at which `hold_n` is sampled 0 (one edge to enter the granting phase, one edge to grant).
- R3: While hold is granted, `hlda_n` returns to 1 after the first rising edge at which `hold_n` is sampled 1.
- R4: If `hold_n` is sampled 1 during the granting phase, the block goes back to normal running, and `hlda_n` never goes to 0 for that request.
- R5: While hold is granted and `ext_fetch` is 0, the rising edge that samples `irq_pend` at 1 drives `intout_n` to 0. `breq_n` stays at 1.
- R6: While hold is granted and `ext_fetch` is 1, the rising edge that samples `irq_pend` at 1 drives `breq_n` to 0, and `intout_n` stays at 1. At the edge where `hold_n` is then sampled 1, `breq_n` and `hlda_n` return to 1, and `intout_n` goes to 0 if `irq_pend` is 1.
- R7: If `hold_n` is 0, `irq_pend` is 1 and `ext_fetch` is 1 at the edge that ends the granting phase, `hlda_n` and `intout_n` both go to 0 at that edge. Both return to 1 at the edge where `hold_n` is sampled 1.
- R8: At any rising edge where `irq_pend` is sampled 0, `intout_n` goes to 1.
- R9: While the block is running normally with `hold_n` at 1, a pending interrupt has no effect on any output, and all three stay at 1.
- R10: The handshake moves through the phases running, granting, held and waiting-for-release, with at most one phase change per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 1 | Active-low bus hold request from the external master |
| irq_pend | input | 1 | High while an interrupt is pending in the core |
| ext_fetch | input | 1 | High while code is fetched from external memory |
| hlda_n | output | 1 | Active-low hold acknowledge |
| breq_n | output | 1 | Active-low request to get the bus back |
| intout_n | output | 1 | Active-low signal that a pending interrupt needs the bus |

## Verification
The assertions assume that `hold_n`, `irq_pend` and `ext_fetch` are already synchronous to `clk` and stable around each rising edge, because the block has no synchronizer of its own. They also assume that `ext_fetch` may change at any cycle, including during hold. The bench changes every input only on the falling edge, and it keeps hold requests long enough to reach the held and waiting phases. Its random phase still toggles `ext_fetch` and `irq_pend` inside a hold, so that interrupts can appear, disappear and reappear in every phase.

// File: rtl/hold_irq_pkg.sv
package hold_irq_pkg;

   typedef enum logic [1:0] {
      PH_RUN     = 2'd0,
      PH_GRANT   = 2'd1,
      PH_HELD    = 2'd2,
      PH_WAITREL = 2'd3
   } hold_ph_e;

   localparam int unsigned PH_COUNT = 4;

endpackage

// File: rtl/hold_phase_next.sv
module hold_phase_next
   import hold_irq_pkg::*;
(
   input  hold_ph_e ph,
   input  logic     hold_n,
   input  logic     irq_pend,
   input  logic     ext_fetch,
   output hold_ph_e ph_nxt
);

   logic ext_irq;
   assign ext_irq = irq_pend & ext_fetch;

   always_comb begin
      ph_nxt = ph;
      unique case (ph)
         PH_RUN:     if (!hold_n) ph_nxt = PH_GRANT;
         PH_GRANT:   ph_nxt = hold_n ? PH_RUN : (ext_irq ? PH_WAITREL : PH_HELD);
         PH_HELD:    if (hold_n) ph_nxt = PH_RUN;
                     else if (ext_irq) ph_nxt = PH_WAITREL;
         PH_WAITREL: if (hold_n) ph_nxt = PH_RUN;
         default:    ph_nxt = PH_RUN;
      endcase
   end

endmodule

// File: rtl/hold_flag_next.sv
module hold_flag_next
   import hold_irq_pkg::*;
(
   input  hold_ph_e ph,
   input  logic     hold_n,
   input  logic     irq_pend,
   input  logic     ext_fetch,
   input  logic     breq_q,
   input  logic     int_q,
   output logic     breq_nxt,
   output logic     int_nxt
);

   always_comb begin
      breq_nxt = breq_q;
      int_nxt  = int_q & irq_pend;
      unique case (ph)
         PH_GRANT: begin
            if (!hold_n && irq_pend && ext_fetch) int_nxt = 1'b1;
         end
         PH_HELD: begin
            if (!hold_n && irq_pend) begin
               if (ext_fetch) breq_nxt = 1'b1;
               else           int_nxt  = 1'b1;
            end
         end
         PH_WAITREL: begin
            if (hold_n) begin
               breq_nxt = 1'b0;
               int_nxt  = breq_q & irq_pend;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/hold_phase_reg.sv
module hold_phase_reg
   import hold_irq_pkg::*;
#(
   parameter int unsigned ONEHOT_STATE = 0
)(
   input  logic     clk,
   input  logic     rst_n,
   input  hold_ph_e ph_nxt,
   output hold_ph_e ph
);

   localparam int unsigned OH_W = PH_COUNT;

   generate
      if (ONEHOT_STATE > 1) begin : g_bad_param
         $error("ONEHOT_STATE must be 0 or 1");
      end

      if (ONEHOT_STATE == 1) begin : g_onehot
         logic [OH_W-1:0] oh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oh_q <= OH_W'(1);
            else        oh_q <= OH_W'(1) << ph_nxt;
         end
         always_comb begin
            ph = PH_RUN;
            for (int i = 0; i < int'(OH_W); i++) begin
               if (oh_q[i]) ph = hold_ph_e'(i);
            end
         end
      end else begin : g_binary
         hold_ph_e ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph_q <= PH_RUN;
            else        ph_q <= ph_nxt;
         end
         assign ph = ph_q;
      end
   endgenerate

endmodule

// File: rtl/hold_irq_arbiter.sv
module hold_irq_arbiter
   import hold_irq_pkg::*;
#(
   parameter int unsigned ONEHOT_STATE = 0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic hold_n,
   input  logic irq_pend,
   input  logic ext_fetch,
   output logic hlda_n,
   output logic breq_n,
   output logic intout_n
);

   hold_ph_e ph, ph_nxt;
   logic     breq_q, int_q, breq_nxt, int_nxt;

   hold_phase_next u_next (
      .ph(ph), .hold_n(hold_n), .irq_pend(irq_pend), .ext_fetch(ext_fetch),
      .ph_nxt(ph_nxt)
   );

   hold_flag_next u_flags (
      .ph(ph), .hold_n(hold_n), .irq_pend(irq_pend), .ext_fetch(ext_fetch),
      .breq_q(breq_q), .int_q(int_q), .breq_nxt(breq_nxt), .int_nxt(int_nxt)
   );

   hold_phase_reg #(.ONEHOT_STATE(ONEHOT_STATE)) u_ph (
      .clk(clk), .rst_n(rst_n), .ph_nxt(ph_nxt), .ph(ph)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         breq_q <= 1'b0;
         int_q  <= 1'b0;
      end else begin
         breq_q <= breq_nxt;
         int_q  <= int_nxt;
      end
   end

   assign hlda_n   = !((ph == PH_HELD) || (ph == PH_WAITREL));
   assign breq_n   = !breq_q;
   assign intout_n = !int_q;

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (hlda_n && breq_n && intout_n)); // R1
   AST_GRANT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hlda_n) |-> $past(!hold_n)); // R2
   AST_HLDA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hlda_n && hold_n) |=> hlda_n); // R3
   AST_GRANT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_GRANT && hold_n) |=> (ph == PH_RUN && hlda_n)); // R4
   AST_INT_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_HELD && !hold_n && irq_pend && !ext_fetch) |=> !intout_n); // R5
   AST_BREQ_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_HELD && !hold_n && irq_pend && ext_fetch) |=> !breq_n); // R6
   AST_BREQ_HANDBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!breq_n && hold_n && irq_pend) |=> (breq_n && hlda_n && !intout_n)); // R6
   AST_BREQ_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !breq_n |-> !hlda_n); // R6
   AST_JOINT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_GRANT && !hold_n && irq_pend && ext_fetch) |=> (!hlda_n && !intout_n)); // R7
   AST_INT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_pend |=> intout_n); // R8
   AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_RUN && hold_n && intout_n) |=> (intout_n && breq_n && hlda_n)); // R9
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_RUN) |=> (ph == PH_RUN || ph == PH_GRANT)); // R10

endmodule

// File: tb/tb_hold_irq_arbiter.sv
module tb_hold_irq_arbiter;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_n = 1'b1, irq_pend = 1'b0, ext_fetch = 1'b0;
   logic hlda_n, breq_n, intout_n;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   hold_irq_arbiter dut (
      .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .irq_pend(irq_pend),
      .ext_fetch(ext_fetch), .hlda_n(hlda_n), .breq_n(breq_n), .intout_n(intout_n)
   );

   // Behavioural reference: phase 0 run, 1 granting, 2 held, 3 waiting release
   int  m_ph = 0;
   bit  m_req = 0, m_int = 0;
   always @(posedge clk) begin
      int  ph_old;
      bit  req_old;
      ph_old  = m_ph;
      req_old = m_req;
      if (!rst_n) begin
         m_ph = 0; m_req = 0; m_int = 0;
      end else begin
         if (!irq_pend) m_int = 0;
         if (hold_n) begin
            if (ph_old == 3) m_int = req_old && irq_pend;
            m_req = 0;
            m_ph  = 0;
         end else begin
            if (ph_old == 0) m_ph = 1;
            else if (ph_old == 1) begin
               m_ph = (irq_pend && ext_fetch) ? 3 : 2;
               if (irq_pend && ext_fetch) m_int = 1;
            end else if (ph_old == 2 && irq_pend) begin
               if (ext_fetch) begin m_ph = 3; m_req = 1; end
               else m_int = 1;
            end
         end
      end
   end

   task automatic chk(input string tag, input bit ok, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: {hlda_n,breq_n,intout_n} actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic expect3(input string tag, input logic [2:0] exp);
      chk(tag, {hlda_n, breq_n, intout_n} === exp, {hlda_n, breq_n, intout_n}, exp);
   endtask

   bit cmp_on = 0;
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         logic [2:0] e;
         e = {!(m_ph == 2 || m_ph == 3), !m_req, !m_int};
         chk("model R10", {hlda_n, breq_n, intout_n} === e, {hlda_n, breq_n, intout_n}, e);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      expect3("R1 in reset", 3'b111);
      step(2);
      rst_n = 1'b1;
      step(1);
      expect3("R1 after reset", 3'b111);
      cmp_on = 1;

      // R9: interrupt while running with hold idle
      irq_pend = 1; ext_fetch = 1; step(3);
      expect3("R9 run ignores irq", 3'b111);
      irq_pend = 0; ext_fetch = 0;

      // R2 / R3
      hold_n = 0; step(1);
      expect3("R2 granting not yet", 3'b111);
      step(1);
      expect3("R2 granted", 3'b011);
      hold_n = 1; step(1);
      expect3("R3 release", 3'b111);

      // R4
      hold_n = 0; step(1);
      hold_n = 1; step(1);
      expect3("R4 abort", 3'b111);
      step(1);
      expect3("R4 abort stays", 3'b111);

      // R5 / R8
      hold_n = 0; step(2);
      irq_pend = 1; ext_fetch = 0; step(1);
      expect3("R5 internal at once", 3'b010);
      irq_pend = 0; step(1);
      expect3("R8 clear in hold", 3'b011);
      hold_n = 1; step(1);

      // R6
      hold_n = 0; step(2);
      irq_pend = 1; ext_fetch = 1; step(1);
      expect3("R6 breq first", 3'b001);
      step(2);
      expect3("R6 waiting", 3'b001);
      hold_n = 1; step(1);
      expect3("R6 handback", 3'b110);
      irq_pend = 0; step(1);
      expect3("R8 clear after handback", 3'b111);

      // R7
      irq_pend = 1; ext_fetch = 1; hold_n = 0; step(1);
      expect3("R7 granting", 3'b111);
      step(1);
      expect3("R7 joint", 3'b010);
      step(2);
      expect3("R7 held joint", 3'b010);
      hold_n = 1; step(1);
      expect3("R7 joint release", 3'b111);
      irq_pend = 0; ext_fetch = 0; step(1);

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 7) == 0) hold_n = ~hold_n;
         if ($urandom_range(0, 4) == 0) irq_pend = ~irq_pend;
         if ($urandom_range(0, 9) == 0) ext_fetch = ~ext_fetch;
         step(1);
      end

      // reset in the middle of a hold
      hold_n = 0; step(3);
      rst_n = 0; step(1);
      expect3("R1 reset mid hold", 3'b111);
      hold_n = 1; rst_n = 1; step(1);
      expect3("R1 quiet after reset", 3'b111);

      summary();
      $finish;
   end

endmodule